// File: doc/BRIEF.md
# Shared Memory Bus Priority Arbiter

This block decides, once per bus cycle, which requester owns a shared memory bus. Some cycles are reserved ahead of time by an external schedule for display fetch, refresh, audio, sprite and floppy traffic. When a cycle is reserved, it goes to the channel the schedule names, and no other requester can contend for it. In every other cycle, the requesters compete in a fixed order. A display coprocessor wins first, then a block-copy engine, then the expansion-card DMA masters, and the host CPU wins last. Under heavy load the CPU can therefore be kept off the bus for a long stretch.

A second, non-shared memory is arbitrated alongside the first. Each expansion master and the CPU flag which of the two memories their request targets. On the secondary memory, any expansion master beats the CPU. When several expansion masters contend for the same memory, the one with the lowest slot identifier wins, or the highest if the parameter `LOW_SLOT_WINS` is 0. If two masters carry equal identifiers, the lower port index wins.

Grants are registered. They change only at a bus-cycle boundary, which is an edge where `cycle_start` is high, and they are held for the whole bus cycle.

Top module: `shared_bus_arbiter`

## Requirements
- R1: At most one grant is high on the shared memory (`sched_gnt`, `copro_gnt`, `blit_gnt`, `exp_gnt`, `cpu_gnt` together), and at most one on the secondary memory (`exp_sec_gnt`, `cpu_sec_gnt`).
- R2: If `rsv_valid` is high at a boundary, then after that edge `sched_gnt` has only bit `rsv_owner` set, and every other shared-memory grant is low, whatever is requested.
- R3: In an unreserved cycle, the shared-memory order is coprocessor, then block-copy engine, then expansion masters, then CPU.
- R4: `cpu_gnt` is set only if the cycle is unreserved and no coprocessor, block-copy or shared-memory expansion request is present.
- R5: Among expansion masters requesting the same memory, the one with the lowest `exp_slot` field wins (`LOW_SLOT_WINS`=1). Master i's field is bits [i*SLOT_W +: SLOT_W]. On equal fields, the lower index wins.
- R6: An expansion master whose `exp_sec` bit is 1 competes only on the secondary memory. There, any expansion request beats a CPU request.
- R7: Grants load only at rising edges where `cycle_start` is 1. They are visible after that edge and do not change at edges where `cycle_start` is 0.
- R8: With no shared-memory request and no reserved cycle, all shared-memory grants are 0. With no secondary request, both secondary grants are 0.
- R9: While `rst_n` is low at an edge, every grant is cleared to 0.
- R10: A CPU request with `cpu_sec`=1 targets only the secondary memory. With `cpu_sec`=0, it targets only the shared memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cycle_start | input | 1 | Bus-cycle boundary strobe; arbitration happens at this edge |
| rsv_valid | input | 1 | Current shared-memory cycle is reserved by the schedule |
| rsv_owner | input | OWN_W | Index of the scheduled channel owning the reserved cycle (< N_SCHED) |
| copro_req | input | 1 | Display coprocessor request (shared memory) |
| blit_req | input | 1 | Block-copy engine request (shared memory) |
| exp_req | input | N_EXP | Expansion DMA master requests |
| exp_sec | input | N_EXP | Per master: 1 = request targets secondary memory |
| exp_slot | input | N_EXP*SLOT_W | Slot identifier of each expansion master |
| cpu_req | input | 1 | Host CPU request |
| cpu_sec | input | 1 | 1 = CPU request targets secondary memory |
| sched_gnt | output | N_SCHED | One-hot grant to the scheduled channel |
| copro_gnt | output | 1 | Coprocessor grant |
| blit_gnt | output | 1 | Block-copy engine grant |
| exp_gnt | output | N_EXP | Expansion master grants on shared memory |
| cpu_gnt | output | 1 | CPU grant on shared memory |
| exp_sec_gnt | output | N_EXP | Expansion master grants on secondary memory |
| cpu_sec_gnt | output | 1 | CPU grant on secondary memory |

## Verification
Within a single boundary, a reserved cycle can collide with the contention chain. It can also collide with slot-number arbitration among expansion masters, and the two memories resolve independently in that same edge. The bench provokes both collisions by sweeping every combination of reservation, each request line, each memory-target bit and three slot layouts, one of them with equal identifiers. It computes the expected winner of each memory from a slot-times-count-plus-index key. Right after every boundary it compares both grant vectors against that model. It then drives the inverted stimulus without a boundary and confirms that both grant vectors are held.

// File: rtl/sbarb_pkg.sv
// Package: shared types for the bus arbiter.
// Assumes slot identifiers are at most SLOT_W_MAX bits wide.
package sbarb_pkg;
    localparam int SLOT_W_MAX = 8;

    // Class of the requester that wins the shared memory in one cycle.
    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_SCHED = 3'd1,
        SRC_COPRO = 3'd2,
        SRC_BLIT  = 3'd3,
        SRC_EXP   = 3'd4,
        SRC_CPU   = 3'd5
    } arb_src_e;
endpackage

// File: rtl/sbarb_slot_pick.sv
// Module: picks one winner among N expansion masters by slot identifier.
// LOW_WINS=1 picks the smallest identifier, 0 the largest; on equal
// identifiers the lower port index wins. Purely combinational.
module sbarb_slot_pick #(
    parameter int N        = 3,
    parameter int SW       = 3,
    parameter bit LOW_WINS = 1'b1
) (
    input  logic [N-1:0]    req,
    input  logic [N*SW-1:0] slot_flat,
    output logic [N-1:0]    win,
    output logic            any
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [SW-1:0]    best;
    logic [IDX_W-1:0] best_idx;
    logic             found;

    // Scan masters in index order; strict compare keeps the lower index on ties.
    always_comb begin
        found    = 1'b0;
        best     = '0;
        best_idx = '0;
        for (int i = 0; i < N; i++) begin
            logic [SW-1:0] cur;
            cur = slot_flat[i*SW +: SW];
            if (req[i] && (!found || (LOW_WINS ? (cur < best) : (cur > best)))) begin
                found    = 1'b1;
                best     = cur;
                best_idx = IDX_W'(i);
            end
        end
    end

    // Expand the chosen index into a one-hot vector.
    always_comb begin
        win = '0;
        for (int i = 0; i < N; i++) begin
            win[i] = found && (best_idx == IDX_W'(i));
        end
    end

    assign any = found;
endmodule

// File: rtl/sbarb_prio_chain.sv
// Module: fixed-priority chain for the shared memory.
// A reserved cycle overrides everything; otherwise coprocessor, block-copy,
// expansion (already reduced to one winner), CPU. Combinational.
// Assumes rsv_owner < N_SCHED whenever rsv_valid is high.
module sbarb_prio_chain
    import sbarb_pkg::*;
#(
    parameter int N_SCHED = 5,
    parameter int N_EXP   = 3,
    parameter int OWN_W   = 3
) (
    input  logic             rsv_valid,
    input  logic [OWN_W-1:0] rsv_owner,
    input  logic             copro_req,
    input  logic             blit_req,
    input  logic [N_EXP-1:0] exp_win,
    input  logic             exp_any,
    input  logic             cpu_req,
    output logic [N_SCHED-1:0] sched_gnt,
    output logic             copro_gnt,
    output logic             blit_gnt,
    output logic [N_EXP-1:0] exp_gnt,
    output logic             cpu_gnt
);
    arb_src_e src;

    // Resolve which requester class owns this cycle.
    always_comb begin
        if (rsv_valid)      src = SRC_SCHED;
        else if (copro_req) src = SRC_COPRO;
        else if (blit_req)  src = SRC_BLIT;
        else if (exp_any)   src = SRC_EXP;
        else if (cpu_req)   src = SRC_CPU;
        else                src = SRC_NONE;
    end

    // Decode the winning class into the grant lines.
    always_comb begin
        sched_gnt = '0;
        for (int i = 0; i < N_SCHED; i++) begin
            sched_gnt[i] = (src == SRC_SCHED) && (rsv_owner == OWN_W'(i));
        end
        copro_gnt = (src == SRC_COPRO);
        blit_gnt  = (src == SRC_BLIT);
        exp_gnt   = (src == SRC_EXP) ? exp_win : '0;
        cpu_gnt   = (src == SRC_CPU);
    end
endmodule

// File: rtl/shared_bus_arbiter.sv
// Module: top of the shared/secondary memory bus arbiter.
// Arbitrates both memories at each edge with cycle_start high and holds the
// registered grants for the rest of the bus cycle. Synchronous active-low reset.
// Assumes slot identifiers fit in SLOT_W bits and rsv_owner < N_SCHED.
module shared_bus_arbiter #(
    parameter int N_SCHED       = 5,
    parameter int N_EXP         = 3,
    parameter int SLOT_W        = 3,
    parameter bit LOW_SLOT_WINS = 1'b1,
    localparam int OWN_W        = (N_SCHED > 1) ? $clog2(N_SCHED) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cycle_start,
    input  logic                    rsv_valid,
    input  logic [OWN_W-1:0]        rsv_owner,
    input  logic                    copro_req,
    input  logic                    blit_req,
    input  logic [N_EXP-1:0]        exp_req,
    input  logic [N_EXP-1:0]        exp_sec,
    input  logic [N_EXP*SLOT_W-1:0] exp_slot,
    input  logic                    cpu_req,
    input  logic                    cpu_sec,
    output logic [N_SCHED-1:0]      sched_gnt,
    output logic                    copro_gnt,
    output logic                    blit_gnt,
    output logic [N_EXP-1:0]        exp_gnt,
    output logic                    cpu_gnt,
    output logic [N_EXP-1:0]        exp_sec_gnt,
    output logic                    cpu_sec_gnt
);
    localparam logic [N_SCHED-1:0] SCHED_ONE = N_SCHED'(1);

    // Per-memory request views and winners.
    logic [N_EXP-1:0]   exp_req_m [2];
    logic [N_EXP-1:0]   exp_win_m [2];
    logic               exp_any_m [2];

    logic [N_SCHED-1:0] sched_nxt;
    logic               copro_nxt, blit_nxt, cpu_nxt, cpu_sec_nxt;
    logic [N_EXP-1:0]   exp_nxt;

    // Split expansion requests by target memory (0 = shared, 1 = secondary).
    assign exp_req_m[0] = exp_req & ~exp_sec;
    assign exp_req_m[1] = exp_req &  exp_sec;

    // One slot-number picker per memory.
    for (genvar m = 0; m < 2; m++) begin : g_mem
        sbarb_slot_pick #(
            .N        (N_EXP),
            .SW       (SLOT_W),
            .LOW_WINS (LOW_SLOT_WINS)
        ) pick_i (
            .req       (exp_req_m[m]),
            .slot_flat (exp_slot),
            .win       (exp_win_m[m]),
            .any       (exp_any_m[m])
        );
    end

    sbarb_prio_chain #(
        .N_SCHED (N_SCHED),
        .N_EXP   (N_EXP),
        .OWN_W   (OWN_W)
    ) chain_i (
        .rsv_valid (rsv_valid),
        .rsv_owner (rsv_owner),
        .copro_req (copro_req),
        .blit_req  (blit_req),
        .exp_win   (exp_win_m[0]),
        .exp_any   (exp_any_m[0]),
        .cpu_req   (cpu_req & ~cpu_sec),
        .sched_gnt (sched_nxt),
        .copro_gnt (copro_nxt),
        .blit_gnt  (blit_nxt),
        .exp_gnt   (exp_nxt),
        .cpu_gnt   (cpu_nxt)
    );

    // Secondary memory: any expansion master beats the CPU.
    assign cpu_sec_nxt = cpu_req && cpu_sec && !exp_any_m[1];

    // Load grants at bus-cycle boundaries, hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sched_gnt   <= '0;
            copro_gnt   <= 1'b0;
            blit_gnt    <= 1'b0;
            exp_gnt     <= '0;
            cpu_gnt     <= 1'b0;
            exp_sec_gnt <= '0;
            cpu_sec_gnt <= 1'b0;
        end else if (cycle_start) begin
            sched_gnt   <= sched_nxt;
            copro_gnt   <= copro_nxt;
            blit_gnt    <= blit_nxt;
            exp_gnt     <= exp_nxt;
            cpu_gnt     <= cpu_nxt;
            exp_sec_gnt <= exp_win_m[1];
            cpu_sec_gnt <= cpu_sec_nxt;
        end
    end

    // R1: one owner per memory.
    a_r1_shared_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sched_gnt, copro_gnt, blit_gnt, exp_gnt, cpu_gnt}));
    a_r1_sec_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exp_sec_gnt, cpu_sec_gnt}));

    // R2: reserved cycle goes to the scheduled owner only.
    a_r2_reserved_owner: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start && rsv_valid |=>
            (sched_gnt == (SCHED_ONE << $past(rsv_owner))) && !copro_gnt
            && !blit_gnt && (exp_gnt == '0) && !cpu_gnt);

    // R3: coprocessor heads the contended chain.
    a_r3_copro_first: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start && !rsv_valid && copro_req |=> copro_gnt);

    // R4: CPU loses to every other shared-memory request.
    a_r4_cpu_last: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start && (rsv_valid || copro_req || blit_req || (exp_req_m[0] != '0))
            |=> !cpu_gnt);

    // R6: on the secondary memory an expansion master beats the CPU.
    a_r6_sec_exp_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start && (exp_req_m[1] != '0) |=> !cpu_sec_gnt && (exp_sec_gnt != '0));

    // R7: grants hold between boundaries.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_start |=> $stable({sched_gnt, copro_gnt, blit_gnt, exp_gnt, cpu_gnt,
                                  exp_sec_gnt, cpu_sec_gnt}));

    // R8: idle shared memory leaves every grant low.
    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start && !rsv_valid && !copro_req && !blit_req
            && (exp_req_m[0] == '0) && !(cpu_req && !cpu_sec)
            |=> {sched_gnt, copro_gnt, blit_gnt, exp_gnt, cpu_gnt} == '0);
endmodule

// File: tb/shared_bus_arbiter_tb_top.sv
// Bench: sweeps every request/target/reservation combination over three slot
// layouts and compares both grant vectors against an arithmetic model.
module shared_bus_arbiter_tb_top;
    localparam int NS = 5;
    localparam int NE = 3;
    localparam int SW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cycle_start = 1'b0;
    logic rsv_valid = 1'b0;
    logic [2:0] rsv_owner = '0;
    logic copro_req = 1'b0, blit_req = 1'b0, cpu_req = 1'b0, cpu_sec = 1'b0;
    logic [NE-1:0] exp_req = '0, exp_sec = '0;
    logic [NE*SW-1:0] exp_slot = '0;
    logic [NS-1:0] sched_gnt;
    logic copro_gnt, blit_gnt, cpu_gnt, cpu_sec_gnt;
    logic [NE-1:0] exp_gnt, exp_sec_gnt;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    shared_bus_arbiter #(.N_SCHED(NS), .N_EXP(NE), .SLOT_W(SW), .LOW_SLOT_WINS(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
        .rsv_valid(rsv_valid), .rsv_owner(rsv_owner),
        .copro_req(copro_req), .blit_req(blit_req),
        .exp_req(exp_req), .exp_sec(exp_sec), .exp_slot(exp_slot),
        .cpu_req(cpu_req), .cpu_sec(cpu_sec),
        .sched_gnt(sched_gnt), .copro_gnt(copro_gnt), .blit_gnt(blit_gnt),
        .exp_gnt(exp_gnt), .cpu_gnt(cpu_gnt),
        .exp_sec_gnt(exp_sec_gnt), .cpu_sec_gnt(cpu_sec_gnt)
    );

    int slots [3][NE] = '{'{2, 7, 5}, '{6, 0, 3}, '{4, 4, 1}};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Winner among requests: smallest slot*NE+index key.
    function automatic logic [NE-1:0] best_of(input logic [NE-1:0] r, input int set);
        int best_key = 1 << 30;
        int best_i = -1;
        logic [NE-1:0] w = '0;
        for (int i = 0; i < NE; i++)
            if (r[i] && (slots[set][i] * NE + i) < best_key) begin
                best_key = slots[set][i] * NE + i;
                best_i = i;
            end
        if (best_i >= 0) w[best_i] = 1'b1;
        return w;
    endfunction

    function automatic logic [31:0] shared_vec();
        return 32'({sched_gnt, copro_gnt, blit_gnt, exp_gnt, cpu_gnt});
    endfunction

    function automatic logic [31:0] sec_vec();
        return 32'({exp_sec_gnt, cpu_sec_gnt});
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R9: reset clears grants despite active requests and boundaries.
        @(negedge clk);
        cycle_start = 1'b1; copro_req = 1'b1; cpu_req = 1'b1; exp_req = '1;
        repeat (3) @(negedge clk);
        check("R9 shared", shared_vec(), 32'd0);
        check("R9 secondary", sec_vec(), 32'd0);
        rst_n = 1'b1;
        cycle_start = 1'b0;

        for (int set = 0; set < 3; set++) begin
            for (int p = 0; p < 2048; p++) begin
                logic [NS-1:0] e_sched;
                logic e_copro, e_blit, e_cpu, e_cpus;
                logic [NE-1:0] e_exp, e_exps, ep, es;
                logic [31:0] e_sh, e_se;
                string tag;
                int n_ep;

                @(negedge clk);
                rsv_valid = p[0]; copro_req = p[1]; blit_req = p[2];
                exp_req = p[5:3]; cpu_req = p[6]; exp_sec = p[9:7]; cpu_sec = p[10];
                rsv_owner = 3'((p + set) % NS);
                for (int i = 0; i < NE; i++) exp_slot[i*SW +: SW] = SW'(slots[set][i]);
                cycle_start = 1'b1;

                // Reference model from the requirements.
                ep = exp_req & ~exp_sec;
                es = exp_req & exp_sec;
                e_sched = '0; e_copro = 0; e_blit = 0; e_exp = '0; e_cpu = 0;
                if (rsv_valid) e_sched[rsv_owner] = 1'b1;
                else if (copro_req) e_copro = 1'b1;
                else if (blit_req) e_blit = 1'b1;
                else if (ep != '0) e_exp = best_of(ep, set);
                else e_cpu = cpu_req && !cpu_sec;
                e_exps = best_of(es, set);
                e_cpus = cpu_req && cpu_sec && (es == '0);
                e_sh = 32'({e_sched, e_copro, e_blit, e_exp, e_cpu});
                e_se = 32'({e_exps, e_cpus});

                n_ep = $countones(ep);
                if (rsv_valid) tag = "R2";
                else if (!copro_req && !blit_req && n_ep >= 2) tag = "R5";
                else if (!copro_req && !blit_req && n_ep == 0 && cpu_req && cpu_sec) tag = "R10";
                else if (!copro_req && !blit_req && n_ep == 0 && !cpu_req) tag = "R8";
                else if (cpu_req && !cpu_sec) tag = "R4";
                else tag = "R3";

                @(negedge clk);
                check(tag, shared_vec(), e_sh);
                check($countones(es) >= 2 ? "R5 secondary" : "R6 secondary", sec_vec(), e_se);
                check("R1 shared onehot", 32'($countones(shared_vec()) <= 1), 32'd1);
                check("R1 secondary onehot", 32'($countones(sec_vec()) <= 1), 32'd1);

                // R7: inverted stimulus without a boundary must not move grants.
                cycle_start = 1'b0;
                rsv_valid = ~rsv_valid; copro_req = ~copro_req; blit_req = ~blit_req;
                exp_req = ~exp_req; exp_sec = ~exp_sec; cpu_req = ~cpu_req; cpu_sec = ~cpu_sec;
                @(negedge clk);
                check("R7 hold shared", shared_vec(), e_sh);
                check("R7 hold secondary", sec_vec(), e_se);
            end
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule